// File: doc/BRIEF.md
# Separable Output Virtual-Channel Allocator

This block hands out output virtual channels of a packet router to the input virtual channels that hold a routed head flit. The router has `P` ports with `V` virtual channels each. An input VC asks for a channel by raising its request with a target output port and a mask of the VCs it will accept on that port. The allocator answers in the same cycle with a valid bit and the binary index of the chosen VC within the target port. The switch stage uses that index to rewrite the flit's VC field.

Matching is done in two separable stages. In the first stage each input VC picks one free candidate from its mask with a V:1 round-robin arbiter. In the second stage each output VC picks one of the input VCs that chose it with a (P*V):1 round-robin arbiter. Every output VC has a busy bit. The bit is set when the VC is granted to a head flit and cleared when the switch reports that the packet's tail has passed. Body and tail flits use the VC their head reserved and never come here. An input VC that loses keeps its request and tries again in later cycles.

Top module: `vc_alloc_sep`

## Requirements
- R1: After reset every output VC is free and no grant is given.
- R2: A grant goes only to an input VC whose request is raised. The granted VC lies on the requested port, and its mask bit is set. `gnt_ovc` holds the binary VC index within that port, and it is zero when no grant is given.
- R3: In any cycle an output VC is granted to at most one input VC, so the number of grants equals the number of distinct output VCs granted.
- R4: A busy output VC is never granted. An output VC granted in one cycle reads busy from the next cycle on. Output VC `o` is VC `o mod V` of port `o / V`.
- R5: A release pulse on a busy output VC clears its busy bit in the next cycle. The released VC cannot be granted in the cycle of the release. A release of a free VC has no effect. If a release and a grant hit the same VC in one cycle, the grant wins.
- R6: First stage. Among the VCs of its mask that are free on the target port, an input VC picks the first one at or after its own pointer, wrapping at V. The pointer moves to the pick plus one (mod V) only when that pick becomes a final grant.
- R7: Second stage. Among the input VCs whose first-stage pick is a given output VC, that output VC grants the first one at or after its own pointer, wrapping at P*V. Input VC `i` is VC `i mod V` of port `i / V`. The pointer moves to the winner plus one whenever it grants.
- R8: If any raised request has at least one free VC in its mask, at least one grant is given in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | P*V | Per input VC: head flit requests an output VC |
| req_port | input | P*V*clog2(P) | Per input VC: target output port |
| req_mask | input | P*V*V | Per input VC: acceptable VCs on the target port |
| rel_ovc | input | P*V | Per output VC: tail flit passed, release the reservation |
| gnt_vld | output | P*V | Per input VC: allocation succeeded this cycle |
| gnt_ovc | output | P*V*clog2(V) | Per input VC: granted VC index within the target port |
| ovc_busy | output | P*V | Per output VC: reserved state |

## Verification
The bench builds the allocator with three ports and three VCs per port. Both counts are not powers of two, so both round-robin pointers must wrap at a value short of their encoding range. With nine input VCs competing for nine output VCs, a directed phase puts every request on one port with a full mask, which drives the second stage into deep contention. A long pseudo-random phase then mixes empty masks, releases of free and of busy VCs, and releases that land on a VC being granted in the same cycle.

// File: rtl/vca_pkg.sv
package vca_pkg;

   // modular increment used by every round-robin pointer
   function automatic int wrap_add(input int base, input int step, input int modulus);
      int s;
      s = base + step;
      while (s >= modulus) s = s - modulus;
      return s;
   endfunction

endpackage

// File: rtl/vca_rr_arb.sv
module vca_rr_arb #(
   parameter int N = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N-1:0]                      req,
   input  logic                              adv,
   output logic [N-1:0]                      gnt,
   output logic [((N > 1) ? $clog2(N) : 1)-1:0] gnt_idx,
   output logic                              any
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("vca_rr_arb needs N >= 2");
   end

   logic [IW-1:0] ptr_q;

   always_comb begin
      int idx;
      gnt     = '0;
      gnt_idx = '0;
      any     = 1'b0;
      for (int k = 0; k < N; k++) begin
         idx = vca_pkg::wrap_add(int'(ptr_q), k, N);
         if (!any && req[idx]) begin
            gnt[idx] = 1'b1;
            gnt_idx  = IW'(idx);
            any      = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (adv && any)
         ptr_q <= IW'(vca_pkg::wrap_add(int'(gnt_idx), 1, N));
   end

endmodule

// File: rtl/vca_busy_tbl.sv
module vca_busy_tbl #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] busy
);
   logic [N-1:0] busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_q <= '0;
      else
         busy_q <= (busy_q & ~clr) | set;
   end

   assign busy = busy_q;

   // R4: a reserved channel is never handed out again
   p_no_regrant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set & busy_q) == '0);

   // R4: a channel granted last cycle now reads busy
   p_set_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(set) & ~busy_q) == '0));

   // R5: a released channel not re-granted is free next cycle
   p_release_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((busy_q & $past(clr & ~set)) == '0));

endmodule

// File: rtl/vc_alloc_sep.sv
module vc_alloc_sep #(
   parameter int P = 5,
   parameter int V = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [P*V-1:0]                     req_vld,
   input  logic [P*V*$clog2(P)-1:0]           req_port,
   input  logic [P*V*V-1:0]                   req_mask,
   input  logic [P*V-1:0]                     rel_ovc,
   output logic [P*V-1:0]                     gnt_vld,
   output logic [P*V*$clog2(V)-1:0]           gnt_ovc,
   output logic [P*V-1:0]                     ovc_busy
);
   localparam int NIV = P * V;
   localparam int NOV = P * V;
   localparam int PW  = $clog2(P);
   localparam int VW  = $clog2(V);

   if (P < 2) begin : g_bad_p
      $error("vc_alloc_sep needs P >= 2");
   end
   if (V < 2) begin : g_bad_v
      $error("vc_alloc_sep needs V >= 2");
   end

   logic [NOV-1:0] busy;
   logic [NOV-1:0] ovc_set;
   logic [NIV-1:0] won;
   logic [NIV-1:0] s1_any;
   logic [NIV-1:0] cand_any;
   logic [VW-1:0]  s1_idx [NIV];
   logic [NIV-1:0] s2_req [NOV];
   logic [NIV-1:0] s2_gnt [NOV];

   // stage one: each input VC chooses one free candidate on its port
   for (genvar i = 0; i < NIV; i++) begin : g_in
      logic [PW-1:0] port_i;
      logic [V-1:0]  cand;
      logic [V-1:0]  s1_gnt;

      assign port_i = req_port[i*PW +: PW];

      always_comb begin
         for (int v = 0; v < V; v++)
            cand[v] = req_vld[i] && req_mask[i*V + v] &&
                      (int'(port_i) < P) && !busy[int'(port_i)*V + v];
      end

      assign cand_any[i] = |cand;

      vca_rr_arb #(.N(V)) u_s1 (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (cand),
         .adv     (won[i]),
         .gnt     (s1_gnt),
         .gnt_idx (s1_idx[i]),
         .any     (s1_any[i])
      );

      assign gnt_vld[i]            = won[i];
      assign gnt_ovc[i*VW +: VW]   = won[i] ? s1_idx[i] : '0;

      // R2: grants only answer raised requests
      p_gnt_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
         won[i] |-> (req_vld[i] && req_mask[i*V + int'(s1_idx[i])]));
   end

   // stage two: each output VC chooses among input VCs that picked it
   for (genvar o = 0; o < NOV; o++) begin : g_out
      for (genvar i = 0; i < NIV; i++) begin : g_col
         assign s2_req[o][i] = s1_any[i] &&
                               (int'(req_port[i*PW +: PW]) == o / V) &&
                               (int'(s1_idx[i]) == o % V);
      end

      logic [$clog2(NIV)-1:0] s2_idx;

      vca_rr_arb #(.N(NIV)) u_s2 (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (s2_req[o]),
         .adv     (1'b1),
         .gnt     (s2_gnt[o]),
         .gnt_idx (s2_idx),
         .any     (ovc_set[o])
      );
   end

   always_comb begin
      won = '0;
      for (int o = 0; o < NOV; o++)
         for (int i = 0; i < NIV; i++)
            won[i] = won[i] | s2_gnt[o][i];
   end

   vca_busy_tbl #(.N(NOV)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ovc_set),
      .clr   (rel_ovc),
      .busy  (busy)
   );

   assign ovc_busy = busy;

   // R3: every grant consumes its own output VC
   p_distinct_ovc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(won) == $countones(ovc_set));

   // R8: a serviceable request never leaves the cycle empty-handed
   p_progress_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|cand_any) |-> (|won));

endmodule

// File: tb/vc_alloc_sep_tb.sv
module vc_alloc_sep_tb;
   localparam int P   = 3;
   localparam int V   = 3;
   localparam int NIV = P * V;
   localparam int NOV = P * V;
   localparam int PW  = $clog2(P);
   localparam int VW  = $clog2(V);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NIV-1:0]      req_vld = '0;
   logic [NIV*PW-1:0]   req_port = '0;
   logic [NIV*V-1:0]    req_mask = '0;
   logic [NOV-1:0]      rel_ovc = '0;
   logic [NIV-1:0]      gnt_vld;
   logic [NIV*VW-1:0]   gnt_ovc;
   logic [NOV-1:0]      ovc_busy;

   always #10 clk = ~clk;

   vc_alloc_sep #(.P(P), .V(V)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_port(req_port),
      .req_mask(req_mask), .rel_ovc(rel_ovc), .gnt_vld(gnt_vld),
      .gnt_ovc(gnt_ovc), .ovc_busy(ovc_busy));

   int n_cmp = 0;
   int n_bad = 0;

   // reference state
   bit rv [NIV];
   int rp [NIV];
   int rm [NIV];
   bit rl [NOV];
   bit m_busy [NOV];
   int ptr1 [NIV];
   int ptr2 [NOV];
   int pick [NIV];
   bit e_won [NIV];
   int e_ovc [NIV];

   task automatic drive();
      for (int i = 0; i < NIV; i++) begin
         req_vld[i]          = rv[i];
         req_port[i*PW +: PW] = PW'(rp[i]);
         req_mask[i*V +: V]  = V'(rm[i]);
      end
      for (int o = 0; o < NOV; o++) rel_ovc[o] = rl[o];
   endtask

   task automatic model_eval(output bit servable);
      servable = 0;
      for (int i = 0; i < NIV; i++) begin
         pick[i] = -1; e_won[i] = 0; e_ovc[i] = -1;
         if (rv[i])
            for (int k = 0; k < V; k++) begin
               int v;
               v = (ptr1[i] + k) % V;
               if (pick[i] < 0 && rm[i][v] && !m_busy[rp[i]*V + v]) pick[i] = v;
            end
         if (pick[i] >= 0) servable = 1;
      end
      for (int o = 0; o < NOV; o++) begin
         int w;
         w = -1;
         for (int k = 0; k < NIV; k++) begin
            int i;
            i = (ptr2[o] + k) % NIV;
            if (w < 0 && pick[i] >= 0 && rp[i]*V + pick[i] == o) w = i;
         end
         if (w >= 0) begin e_won[w] = 1; e_ovc[w] = o; end
      end
   endtask

   task automatic compare(input bit servable);
      bit bad_b;
      int ng;
      ng = 0;
      for (int i = 0; i < NIV; i++) begin
         int exp_idx, act_idx;
         exp_idx = e_won[i] ? (e_ovc[i] % V) : 0;
         act_idx = int'(gnt_ovc[i*VW +: VW]);
         n_cmp++;
         if (gnt_vld[i] !== e_won[i] || act_idx != exp_idx) begin
            n_bad++;
            $display("FAIL R2 R3 R6 R7 ivc %0d: got vld=%0b idx=%0d expected vld=%0b idx=%0d",
                     i, gnt_vld[i], act_idx, e_won[i], exp_idx);
         end
         if (gnt_vld[i] === 1'b1) ng++;
      end
      bad_b = 0;
      for (int o = 0; o < NOV; o++) if (ovc_busy[o] !== m_busy[o]) bad_b = 1;
      n_cmp++;
      if (bad_b) begin
         n_bad++;
         $display("FAIL R4 R5 busy: got %b expected %p", ovc_busy, m_busy);
      end
      if (servable) begin
         n_cmp++;
         if (ng == 0) begin
            n_bad++;
            $display("FAIL R8 no grant while servable: got 0 grants expected >=1");
         end
      end
   endtask

   task automatic model_update();
      for (int i = 0; i < NIV; i++)
         if (e_won[i]) begin
            ptr1[i] = (pick[i] + 1) % V;
            ptr2[e_ovc[i]] = (i + 1) % NIV;
         end
      for (int o = 0; o < NOV; o++) if (rl[o]) m_busy[o] = 0;
      for (int i = 0; i < NIV; i++)
         if (e_won[i]) begin m_busy[e_ovc[i]] = 1; rv[i] = 0; end
   endtask

   task automatic step();
      bit s;
      drive();
      #5;
      model_eval(s);
      compare(s);
      model_update();
   endtask

   initial begin
      for (int i = 0; i < NIV; i++) begin rv[i] = 0; rp[i] = 0; rm[i] = 0; ptr1[i] = 0; end
      for (int o = 0; o < NOV; o++) begin rl[o] = 0; m_busy[o] = 0; ptr2[o] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #5;
      // R1: reset state
      n_cmp++;
      if (ovc_busy !== '0 || gnt_vld !== '0) begin
         n_bad++;
         $display("FAIL R1 reset: got busy=%b gnt=%b expected 0 and 0", ovc_busy, gnt_vld);
      end
      // directed: everyone wants port 0 with a full mask (R7 contention, wrap)
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         for (int i = 0; i < NIV; i++) begin
            if (!rv[i]) begin rv[i] = 1; rp[i] = 0; rm[i] = (1 << V) - 1; end
         end
         for (int o = 0; o < NOV; o++) rl[o] = (c % 3 == 2);
         step();
      end
      // directed: single input VC, partial masks, release of free VCs (R5 R6)
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         for (int i = 0; i < NIV; i++) rv[i] = 0;
         rv[4] = 1; rp[4] = c % P; rm[4] = (c % 7) + 1;
         for (int o = 0; o < NOV; o++) rl[o] = ((c + o) % 4 == 0);
         step();
      end
      // pseudo-random mix
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         for (int i = 0; i < NIV; i++) begin
            if (!rv[i] && ($urandom % 10) < 4) begin
               rv[i] = 1; rp[i] = $urandom % P; rm[i] = $urandom % (1 << V);
            end else if (rv[i] && ($urandom % 10) == 0) rv[i] = 0;
         end
         for (int o = 0; o < NOV; o++) rl[o] = (($urandom % 4) == 0);
         step();
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule